// File: doc/BRIEF.md
# Multifunction Integer ALU

This block is the purely combinational arithmetic and logic unit of a small load/store processor core. It takes two 32-bit operands, `x_in` and `y_in`, and a set of control fields. It returns one 32-bit result together with an overflow flag and a zero flag. The control fields are the operation class, the add/subtract selection, the logic operation, the shift kind and the source of the shift amount. Operand selection, the register file and any trap on overflow are handled by the surrounding datapath. That datapath reads the result and the flags in the same cycle it drives the controls.

A single adder serves addition, subtraction, set-less-than and the zero flag. When subtracting, the adder inverts `y_in` and injects a carry of one. The shifter always moves `y_in`. It takes its distance either from a 5-bit constant field or from the low five bits of `x_in`. Loading an upper immediate is not a separate operation. It is done in the shift class as a logical left shift of `y_in` by the constant 16.

Top module: `alu32`

## Requirements
- R1: The operation class `op_class` selects the result source as follows: 2'b00 gives the shifter, 2'b01 gives set-less-than, 2'b10 gives the adder and 2'b11 gives the logic unit.
- R2: In the arithmetic class, the result is `x_in + y_in` modulo 2^32 when `sub_en`=0, and `x_in - y_in` modulo 2^32 when `sub_en`=1.
- R3: In the set-less-than class with `sub_en`=1, the result has all bits zero except bit 0. Bit 0 equals bit 31 of the 32-bit difference `x_in - y_in`, that is, the raw sign of the difference with no overflow correction.
- R4: In the logic class, `logic_op` selects the operation as follows: 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives XOR and 2'b11 gives NOR.
- R5: In the shift class, `shift_op` selects the shift applied to `y_in` as follows: 2'b00 passes `y_in` through unchanged, 2'b01 is a logical left shift, 2'b10 is a logical right shift and 2'b11 is an arithmetic right shift.
- R6: When `amt_from_x`=0, the shift distance is `amt_const`. When `amt_from_x`=1, the shift distance is `x_in[4:0]`, and bits 31:5 of `x_in` have no effect on the result.
- R7: With op class 2'b00, `shift_op`=2'b01, `amt_from_x`=0 and `amt_const`=16, the result is `{y_in[15:0], 16'h0000}`. This is the load-upper-immediate operation.
- R8: `zero` is 1 exactly when the 32-bit adder output (`x_in` plus or minus `y_in`, as set by `sub_en`) is zero, in every operation class.
- R9: In the arithmetic class, `ovfl` is 1 exactly when the signed two's-complement sum or difference falls outside the range -2^31 to 2^31-1.
- R10: `ovfl` is 0 in every operation class other than arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 32 | First operand; its low 5 bits are the variable shift distance |
| y_in | input | 32 | Second operand; the value that is shifted |
| op_class | input | 2 | Operation class select |
| sub_en | input | 1 | 1 = subtract (invert y, carry-in 1) |
| logic_op | input | 2 | Logic operation select |
| shift_op | input | 2 | Shift kind select |
| amt_from_x | input | 1 | 1 = shift distance from x_in[4:0] |
| amt_const | input | 5 | Constant shift distance |
| result | output | 32 | Selected result |
| ovfl | output | 1 | Signed overflow, arithmetic class only |
| zero | output | 1 | Adder output is zero |

## Verification
Every output is combinational, so `result`, `ovfl` and `zero` are all due zero cycles after the inputs change, with no register on any path. The bench changes the inputs on the falling clock edge and samples the outputs 2 ns later. This keeps every check well away from the rising edge and after the combinational logic has settled. Each scenario task compares all three outputs against a reference model written from the requirements, which uses 64-bit signed arithmetic for the sums and their overflow.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W = 32
) (
  input  logic [W-1:0]         x_in,
  input  logic [W-1:0]         y_in,
  input  logic [1:0]           op_class,
  input  logic                 sub_en,
  input  logic [1:0]           logic_op,
  input  logic [1:0]           shift_op,
  input  logic                 amt_from_x,
  input  logic [$clog2(W)-1:0] amt_const,
  output logic [W-1:0]         result,
  output logic                 ovfl,
  output logic                 zero
);
  localparam int AW = $clog2(W);

  logic [W-1:0]  y_eff;
  logic [W-1:0]  sum;
  logic          c_out;
  logic          c_msb;
  logic [AW-1:0] amt;
  logic [W-1:0]  sh_out;
  logic [W-1:0]  lg_out;

  assign y_eff          = y_in ^ {W{sub_en}};
  assign {c_out, sum}   = {1'b0, x_in} + {1'b0, y_eff} + {{W{1'b0}}, sub_en};
  assign c_msb          = x_in[W-1] ^ y_eff[W-1] ^ sum[W-1];
  assign zero           = ~|sum;
  assign ovfl           = (op_class == 2'b10) & (c_out ^ c_msb);

  assign amt = amt_from_x ? x_in[AW-1:0] : amt_const;

  always_comb begin
    case (shift_op)
      2'b01:   sh_out = y_in << amt;
      2'b10:   sh_out = y_in >> amt;
      2'b11:   sh_out = W'($signed(y_in) >>> amt);
      default: sh_out = y_in;
    endcase
  end

  always_comb begin
    case (logic_op)
      2'b00:   lg_out = x_in & y_in;
      2'b01:   lg_out = x_in | y_in;
      2'b10:   lg_out = x_in ^ y_in;
      default: lg_out = ~(x_in | y_in);
    endcase
  end

  always_comb begin
    case (op_class)
      2'b00:   result = sh_out;
      2'b01:   result = {{(W-1){1'b0}}, sum[W-1]};
      2'b10:   result = sum;
      default: result = lg_out;
    endcase
  end
endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]         x_in,
  input logic [W-1:0]         y_in,
  input logic [1:0]           op_class,
  input logic                 sub_en,
  input logic [1:0]           logic_op,
  input logic [1:0]           shift_op,
  input logic                 amt_from_x,
  input logic [$clog2(W)-1:0] amt_const,
  input logic [W-1:0]         result,
  input logic                 ovfl,
  input logic                 zero
);
  always_comb begin
    // R10
    ovfl_class_chk: assert (op_class == 2'b10 || !ovfl);
    // R3
    slt_upper_chk: assert (op_class != 2'b01 || result[W-1:1] == '0);
    // R5
    pass_shift_chk: assert (op_class != 2'b00 || shift_op != 2'b00 || result == y_in);
    // R8
    zero_eq_chk: assert (!sub_en || zero == (x_in == y_in));
    // R9
    ovfl_sign_chk: assert (!ovfl || (sub_en ? (x_in[W-1] != y_in[W-1]) : (x_in[W-1] == y_in[W-1])));
    // R4
    nor_chk: assert (op_class != 2'b11 || logic_op != 2'b11 || (result & (x_in | y_in)) == '0);
  end
endmodule

bind alu32 alu32_chk #(.W(W)) chk_i (
  .x_in(x_in), .y_in(y_in), .op_class(op_class), .sub_en(sub_en),
  .logic_op(logic_op), .shift_op(shift_op), .amt_from_x(amt_from_x),
  .amt_const(amt_const), .result(result), .ovfl(ovfl), .zero(zero)
);

// File: tb/alu32_tb_top.sv
module alu32_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] x_in, y_in, result;
  logic [1:0]  op_class, logic_op, shift_op;
  logic        sub_en, amt_from_x, ovfl, zero;
  logic [4:0]  amt_const;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5679;

  alu32 dut_i (
    .x_in(x_in), .y_in(y_in), .op_class(op_class), .sub_en(sub_en),
    .logic_op(logic_op), .shift_op(shift_op), .amt_from_x(amt_from_x),
    .amt_const(amt_const), .result(result), .ovfl(ovfl), .zero(zero)
  );

  function automatic logic [31:0] nextr();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic model(output logic [31:0] r, output logic o, output logic z);
    longint sx, sy, d;
    logic [31:0] s;
    logic [4:0] a;
    sx = longint'($signed(x_in));
    sy = longint'($signed(y_in));
    d  = sub_en ? sx - sy : sx + sy;
    s  = d[31:0];
    z  = (s == 32'd0);
    o  = (op_class == 2'b10) && (d > 64'sd2147483647 || d < -64'sd2147483648);
    a  = amt_from_x ? x_in[4:0] : amt_const;
    case (op_class)
      2'b00: case (shift_op)
        2'b00: r = y_in;
        2'b01: r = y_in << a;
        2'b10: r = y_in >> a;
        default: r = 32'($signed(y_in) >>> a);
      endcase
      2'b01: r = {31'd0, s[31]};
      2'b10: r = s;
      default: case (logic_op)
        2'b00: r = x_in & y_in;
        2'b01: r = x_in | y_in;
        2'b10: r = x_in ^ y_in;
        default: r = ~(x_in | y_in);
      endcase
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [1:0] fc,
                       input logic sb, input logic [1:0] lf, input logic [1:0] sf,
                       input logic sv, input logic [4:0] sc);
    @(negedge clk);
    x_in = x; y_in = y; op_class = fc; sub_en = sb;
    logic_op = lf; shift_op = sf; amt_from_x = sv; amt_const = sc;
    #2;
  endtask

  task automatic run(input string tag, input logic [31:0] x, input logic [31:0] y,
                     input logic [1:0] fc, input logic sb, input logic [1:0] lf,
                     input logic [1:0] sf, input logic sv, input logic [4:0] sc);
    logic [31:0] r;
    logic o, z;
    apply(x, y, fc, sb, lf, sf, sv, sc);
    model(r, o, z);
    chk({tag, " result"}, result, r);
    chk({tag, " ovfl"}, {31'd0, ovfl}, {31'd0, o});
    chk({tag, " zero"}, {31'd0, zero}, {31'd0, z});
  endtask

  task automatic t_reset;
    apply(0, 0, 2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0);
    chk("R2 idle result", result, 32'd0);
    chk("R8 idle zero", {31'd0, zero}, 32'd1);
    chk("R9 idle ovfl", {31'd0, ovfl}, 32'd0);
  endtask

  task automatic t_arith;
    run("R2 add", 32'd7, 32'd5, 2'b10, 0, 0, 0, 0, 0);
    run("R2 sub", 32'd5, 32'd7, 2'b10, 1, 0, 0, 0, 0);
    run("R9 add pos ovf", 32'h7fff_ffff, 32'd1, 2'b10, 0, 0, 0, 0, 0);
    run("R9 sub neg ovf", 32'h8000_0000, 32'd1, 2'b10, 1, 0, 0, 0, 0);
    run("R9 add neg ovf", 32'h8000_0000, 32'hffff_ffff, 2'b10, 0, 0, 0, 0, 0);
    chk("R9 ovfl set", {31'd0, ovfl}, 32'd1);
    run("R2 wrap no ovf", 32'hffff_ffff, 32'd1, 2'b10, 0, 0, 0, 0, 0);
  endtask

  task automatic t_slt;
    run("R3 lt", 32'd3, 32'd9, 2'b01, 1, 0, 0, 0, 0);
    chk("R3 lt bit", result, 32'd1);
    run("R3 ge", 32'd9, 32'd3, 2'b01, 1, 0, 0, 0, 0);
    run("R3 neg", 32'hffff_fff0, 32'd2, 2'b01, 1, 0, 0, 0, 0);
    run("R3 raw sign", 32'h8000_0000, 32'd1, 2'b01, 1, 0, 0, 0, 0);
    chk("R3 raw sign bit", result, 32'd0);
    chk("R10 slt ovfl", {31'd0, ovfl}, 32'd0);
  endtask

  task automatic t_logic;
    for (int i = 0; i < 4; i++)
      run("R4 logic", 32'hf0f0_cc33, 32'hff00_a5a5, 2'b11, 0, 2'(i), 0, 0, 0);
    chk("R1 R4 nor", result, ~(32'hf0f0_cc33 | 32'hff00_a5a5));
  endtask

  task automatic t_shift;
    for (int i = 0; i < 4; i++) begin
      run("R5 shift c3", 32'd0, 32'h8001_0f00, 2'b00, 0, 0, 2'(i), 0, 5'd3);
      run("R5 shift c31", 32'd0, 32'h8001_0f00, 2'b00, 0, 0, 2'(i), 0, 5'd31);
    end
    run("R5 sra", 32'd0, 32'h8000_0000, 2'b00, 0, 0, 2'b11, 0, 5'd4);
    chk("R5 sra value", result, 32'hf800_0000);
  endtask

  task automatic t_amount;
    run("R6 var", 32'hffff_ffe4, 32'h0000_00ff, 2'b00, 0, 0, 2'b01, 1, 5'd1);
    chk("R6 var value", result, 32'h0000_0ff0);
    run("R6 upper x ignored", 32'h0000_0004, 32'h0000_00ff, 2'b00, 0, 0, 2'b01, 1, 5'd1);
    chk("R6 upper x ignored value", result, 32'h0000_0ff0);
    run("R6 const", 32'd7, 32'h0000_00ff, 2'b00, 0, 0, 2'b10, 0, 5'd4);
    chk("R6 const value", result, 32'h0000_000f);
  endtask

  task automatic t_lui;
    run("R7 lui", 32'h1234_5678, 32'hdead_beef, 2'b00, 0, 0, 2'b01, 0, 5'd16);
    chk("R7 lui value", result, 32'hbeef_0000);
  endtask

  task automatic t_flags;
    run("R8 zero in logic class", 32'd42, 32'd42, 2'b11, 1, 2'b01, 0, 0, 0);
    chk("R8 zero set", {31'd0, zero}, 32'd1);
    run("R10 shift ovfl", 32'h7fff_ffff, 32'd1, 2'b00, 0, 0, 0, 0, 0);
    chk("R10 ovfl clear", {31'd0, ovfl}, 32'd0);
    run("R8 zero add", 32'hffff_fffb, 32'd5, 2'b10, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] c;
      c = nextr();
      run("R1 sweep", nextr(), (i % 5 == 0) ? 32'h8000_0000 : nextr(), c[1:0], c[2],
          c[4:3], c[6:5], c[7], c[12:8]);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    x_in = 0; y_in = 0; op_class = 0; sub_en = 0;
    logic_op = 0; shift_op = 0; amt_from_x = 0; amt_const = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_arith;
    t_slt;
    t_logic;
    t_shift;
    t_amount;
    t_lui;
    t_flags;
    t_sweep;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule